// File: doc/BRIEF.md
# Operand Bypass Selector

This block picks the freshest copy of each source operand for a five-stage in-order pipeline, so that a dependent instruction does not have to wait for its producer to reach the register file. It serves four consumers. The two ALU operand inputs and the store-data path belong to the instruction in the execute stage. The branch zero test belongs to the instruction in the decode stage. For each consumer it compares the source register number with the destinations of the instructions further down the pipe and returns a 2-bit select code together with the selected value.

The execute-stage consumers can draw on the result latch between execute and memory access (called stage result 0 here) and the latch between memory access and write-back (stage result 1). The zero test sits one stage earlier, so it can also draw on the ALU result of the instruction currently in execute, before that result is latched. A load produces its data only in memory access, so the unit forwards load data only from stage result 1. When a load in execute or in stage result 0 matches a source, the unit selects the register-file value and the stall logic outside the block holds the consumer. The unit is purely combinational. Stall generation, the ALU and the register file are outside the block.

Top module: `operand_bypass_unit`

## Requirements
- R1: For ALU operand A the select code is 01 with the stage result 0 value when that producer matches, 10 with the stage result 1 value when only that producer matches, and 00 with the register-file value when none match.
- R2: When several producers match the same source, the youngest one wins. For the execute-stage consumers stage result 0 beats stage result 1. For the zero test the order is live ALU output, then stage result 0, then stage result 1.
- R3: Source register 0 is never forwarded. A producer whose write flag is low (a store or a NOP) is never matched. In both cases the select code is 00.
- R4: When the immediate flag is set, ALU operand B has select code 11 and carries the immediate, whatever the producer matches. When the flag is clear, operand B forwards from source 2 under the same rules as operand A.
- R5: When the link flag is set, ALU operand A has select code 00 and carries the return address (PC+4), whatever the producer matches.
- R6: The store-data path forwards from source 2 using only codes 00, 01 and 10, independent of the immediate flag, and it never uses the live ALU output.
- R7: The zero-test operand uses code 11 with the live ALU value when the instruction in execute writes a matching register. It uses codes 01 and 10 for the stage result latches and 00 for its own register-file value.
- R8: A load that is still in execute or in stage result 0 and matches a source is not forwarded. It also hides any older match, so the select code is 00. A matching load result held in stage result 1 is forwarded with code 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exSrc1 | input | REG_AW | Source register 1 of the instruction in execute |
| exSrc2 | input | REG_AW | Source register 2 of the instruction in execute (also the store-data source) |
| exUseImm | input | 1 | Operand B takes the immediate |
| exIsLink | input | 1 | Operand A takes the return address |
| exRf1 | input | DATA_W | Register-file value for source 1 |
| exRf2 | input | DATA_W | Register-file value for source 2 |
| exImm | input | DATA_W | Sign-extended immediate |
| exPcPlus4 | input | DATA_W | Return address for link instructions |
| idZeroSrc | input | REG_AW | Source register of the branch in decode |
| idZeroRf | input | DATA_W | Register-file value for the branch source |
| liveDest | input | REG_AW | Destination of the instruction in execute |
| liveWrites | input | 1 | Instruction in execute writes a register |
| liveIsLoad | input | 1 | Instruction in execute is a load |
| liveAlu | input | DATA_W | Unlatched ALU output of the instruction in execute |
| out0Dest | input | REG_AW | Destination held in stage result 0 |
| out0Writes | input | 1 | Stage result 0 writes a register |
| out0IsLoad | input | 1 | Stage result 0 belongs to a load |
| out0Data | input | DATA_W | Stage result 0 value |
| out1Dest | input | REG_AW | Destination held in stage result 1 |
| out1Writes | input | 1 | Stage result 1 writes a register |
| out1Data | input | DATA_W | Stage result 1 value (load data included) |
| aluASel | output | 2 | Operand A select code |
| aluA | output | DATA_W | Operand A value |
| aluBSel | output | 2 | Operand B select code |
| aluB | output | DATA_W | Operand B value |
| storeSel | output | 2 | Store-data select code |
| storeData | output | DATA_W | Store-data value |
| zeroSel | output | 2 | Zero-test select code |
| zeroOperand | output | DATA_W | Zero-test operand value |

## Verification
Several paths can resolve in the same evaluation. In one case the immediate replaces operand B while the store-data path forwards the same source 2 from a stage latch. In another the zero test takes the live ALU value while operand A forwards from a latch. The vectors set these combinations together with overlapping destinations, flagged loads and register 0, and each select code and value is compared with the result predicted from the priority and load rules. Every value input carries a distinct constant, so a wrong data leg shows up even when the select code is correct.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam logic [1:0] SEL_RF   = 2'b00;
  localparam logic [1:0] SEL_OUT0 = 2'b01;
  localparam logic [1:0] SEL_OUT1 = 2'b10;
  localparam logic [1:0] SEL_ALT  = 2'b11;

  typedef struct packed {
    logic [1:0] aSel;
    logic [1:0] bSel;
    logic [1:0] sSel;
    logic [1:0] zSel;
    logic       aLink;
  } fwdStrobes_t;
endpackage

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_pkg::*;
#(
  parameter int REG_AW   = 5,
  parameter bit USE_LIVE = 1'b0
) (
  input  logic [REG_AW-1:0] src,
  input  logic              srcValid,
  input  logic [REG_AW-1:0] liveDest,
  input  logic              liveWrites,
  input  logic              liveIsLoad,
  input  logic [REG_AW-1:0] out0Dest,
  input  logic              out0Writes,
  input  logic              out0IsLoad,
  input  logic [REG_AW-1:0] out1Dest,
  input  logic              out1Writes,
  output logic [1:0]        sel
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic srcLive;
  logic liveHit;
  logic out0Hit;
  logic out1Hit;

  assign srcLive = srcValid && (src != ZERO_REG);
  assign liveHit = USE_LIVE && srcLive && liveWrites && (liveDest == src);
  assign out0Hit = srcLive && out0Writes && (out0Dest == src);
  assign out1Hit = srcLive && out1Writes && (out1Dest == src);

  always_comb begin
    if (liveHit) begin
      sel = liveIsLoad ? SEL_RF : SEL_ALT;
    end else if (out0Hit) begin
      sel = out0IsLoad ? SEL_RF : SEL_OUT0;
    end else if (out1Hit) begin
      sel = SEL_OUT1;
    end else begin
      sel = SEL_RF;
    end
  end
endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] exSrc1,
  input  logic [REG_AW-1:0] exSrc2,
  input  logic              exUseImm,
  input  logic              exIsLink,
  input  logic [REG_AW-1:0] idZeroSrc,
  input  logic [REG_AW-1:0] liveDest,
  input  logic              liveWrites,
  input  logic              liveIsLoad,
  input  logic [REG_AW-1:0] out0Dest,
  input  logic              out0Writes,
  input  logic              out0IsLoad,
  input  logic [REG_AW-1:0] out1Dest,
  input  logic              out1Writes,
  output fwdStrobes_t       strobes
);
  localparam int N_PATH = 4;
  localparam int P_A = 0;
  localparam int P_B = 1;
  localparam int P_S = 2;
  localparam int P_Z = 3;

  logic [REG_AW-1:0] pathSrc   [N_PATH];
  logic              pathValid [N_PATH];
  logic [1:0]        pathSel   [N_PATH];

  assign pathSrc[P_A]   = exSrc1;
  assign pathValid[P_A] = !exIsLink;
  assign pathSrc[P_B]   = exSrc2;
  assign pathValid[P_B] = !exUseImm;
  assign pathSrc[P_S]   = exSrc2;
  assign pathValid[P_S] = 1'b1;
  assign pathSrc[P_Z]   = idZeroSrc;
  assign pathValid[P_Z] = 1'b1;

  for (genvar p = 0; p < N_PATH; p++) begin : g_path
    fwd_match #(
      .REG_AW  (REG_AW),
      .USE_LIVE(p == P_Z)
    ) match_i (
      .src       (pathSrc[p]),
      .srcValid  (pathValid[p]),
      .liveDest  (liveDest),
      .liveWrites(liveWrites),
      .liveIsLoad(liveIsLoad),
      .out0Dest  (out0Dest),
      .out0Writes(out0Writes),
      .out0IsLoad(out0IsLoad),
      .out1Dest  (out1Dest),
      .out1Writes(out1Writes),
      .sel       (pathSel[p])
    );
  end

  always_comb begin
    strobes.aSel  = pathSel[P_A];
    strobes.bSel  = exUseImm ? SEL_ALT : pathSel[P_B];
    strobes.sSel  = pathSel[P_S];
    strobes.zSel  = pathSel[P_Z];
    strobes.aLink = exIsLink;
  end
endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwdStrobes_t       strobes,
  input  logic [DATA_W-1:0] exRf1,
  input  logic [DATA_W-1:0] exRf2,
  input  logic [DATA_W-1:0] exImm,
  input  logic [DATA_W-1:0] exPcPlus4,
  input  logic [DATA_W-1:0] idZeroRf,
  input  logic [DATA_W-1:0] liveAlu,
  input  logic [DATA_W-1:0] out0Data,
  input  logic [DATA_W-1:0] out1Data,
  output logic [DATA_W-1:0] aluA,
  output logic [DATA_W-1:0] aluB,
  output logic [DATA_W-1:0] storeData,
  output logic [DATA_W-1:0] zeroOperand
);
  logic [DATA_W-1:0] baseA;

  assign baseA = strobes.aLink ? exPcPlus4 : exRf1;

  always_comb begin
    unique case (strobes.aSel)
      SEL_OUT0: aluA = out0Data;
      SEL_OUT1: aluA = out1Data;
      default:  aluA = baseA;
    endcase
    unique case (strobes.bSel)
      SEL_OUT0: aluB = out0Data;
      SEL_OUT1: aluB = out1Data;
      SEL_ALT:  aluB = exImm;
      default:  aluB = exRf2;
    endcase
    unique case (strobes.sSel)
      SEL_OUT0: storeData = out0Data;
      SEL_OUT1: storeData = out1Data;
      default:  storeData = exRf2;
    endcase
    unique case (strobes.zSel)
      SEL_OUT0: zeroOperand = out0Data;
      SEL_OUT1: zeroOperand = out1Data;
      SEL_ALT:  zeroOperand = liveAlu;
      default:  zeroOperand = idZeroRf;
    endcase
  end
endmodule

// File: rtl/operand_bypass_unit.sv
module operand_bypass_unit
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] exSrc1,
  input  logic [REG_AW-1:0] exSrc2,
  input  logic              exUseImm,
  input  logic              exIsLink,
  input  logic [DATA_W-1:0] exRf1,
  input  logic [DATA_W-1:0] exRf2,
  input  logic [DATA_W-1:0] exImm,
  input  logic [DATA_W-1:0] exPcPlus4,
  input  logic [REG_AW-1:0] idZeroSrc,
  input  logic [DATA_W-1:0] idZeroRf,
  input  logic [REG_AW-1:0] liveDest,
  input  logic              liveWrites,
  input  logic              liveIsLoad,
  input  logic [DATA_W-1:0] liveAlu,
  input  logic [REG_AW-1:0] out0Dest,
  input  logic              out0Writes,
  input  logic              out0IsLoad,
  input  logic [DATA_W-1:0] out0Data,
  input  logic [REG_AW-1:0] out1Dest,
  input  logic              out1Writes,
  input  logic [DATA_W-1:0] out1Data,
  output logic [1:0]        aluASel,
  output logic [DATA_W-1:0] aluA,
  output logic [1:0]        aluBSel,
  output logic [DATA_W-1:0] aluB,
  output logic [1:0]        storeSel,
  output logic [DATA_W-1:0] storeData,
  output logic [1:0]        zeroSel,
  output logic [DATA_W-1:0] zeroOperand
);
  fwdStrobes_t strobes;

  fwd_ctrl #(.REG_AW(REG_AW)) ctrl_i (
    .exSrc1    (exSrc1),
    .exSrc2    (exSrc2),
    .exUseImm  (exUseImm),
    .exIsLink  (exIsLink),
    .idZeroSrc (idZeroSrc),
    .liveDest  (liveDest),
    .liveWrites(liveWrites),
    .liveIsLoad(liveIsLoad),
    .out0Dest  (out0Dest),
    .out0Writes(out0Writes),
    .out0IsLoad(out0IsLoad),
    .out1Dest  (out1Dest),
    .out1Writes(out1Writes),
    .strobes   (strobes)
  );

  fwd_datapath #(.DATA_W(DATA_W)) dp_i (
    .strobes    (strobes),
    .exRf1      (exRf1),
    .exRf2      (exRf2),
    .exImm      (exImm),
    .exPcPlus4  (exPcPlus4),
    .idZeroRf   (idZeroRf),
    .liveAlu    (liveAlu),
    .out0Data   (out0Data),
    .out1Data   (out1Data),
    .aluA       (aluA),
    .aluB       (aluB),
    .storeData  (storeData),
    .zeroOperand(zeroOperand)
  );

  assign aluASel  = strobes.aSel;
  assign aluBSel  = strobes.bSel;
  assign storeSel = strobes.sSel;
  assign zeroSel  = strobes.zSel;
endmodule

// File: rtl/operand_bypass_chk.sv
module operand_bypass_chk #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] exSrc1,
  input logic [REG_AW-1:0] exSrc2,
  input logic              exUseImm,
  input logic              exIsLink,
  input logic [DATA_W-1:0] exImm,
  input logic [DATA_W-1:0] exPcPlus4,
  input logic [REG_AW-1:0] idZeroSrc,
  input logic [REG_AW-1:0] liveDest,
  input logic              liveWrites,
  input logic              liveIsLoad,
  input logic [DATA_W-1:0] liveAlu,
  input logic [REG_AW-1:0] out0Dest,
  input logic              out0Writes,
  input logic              out0IsLoad,
  input logic [REG_AW-1:0] out1Dest,
  input logic              out1Writes,
  input logic [DATA_W-1:0] out1Data,
  input logic [1:0]        aluASel,
  input logic [DATA_W-1:0] aluA,
  input logic [1:0]        aluBSel,
  input logic [DATA_W-1:0] aluB,
  input logic [1:0]        storeSel,
  input logic [1:0]        zeroSel,
  input logic [DATA_W-1:0] zeroOperand
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic m0A;
  logic m1A;
  logic liveZ;

  assign m0A   = out0Writes && (out0Dest == exSrc1) && (exSrc1 != ZERO_REG) && !exIsLink;
  assign m1A   = out1Writes && (out1Dest == exSrc1);
  assign liveZ = liveWrites && !liveIsLoad && (liveDest == idZeroSrc) && (idZeroSrc != ZERO_REG);

  always_comb begin
    AST_OUT1_DATA: assert (aluASel != 2'b10 || aluA == out1Data) else $error("operand A code 10 without stage result 1 value"); // R1
    AST_YOUNGEST_WINS: assert (!(m0A && m1A && !out0IsLoad) || aluASel == 2'b01) else $error("older producer chosen"); // R2
    AST_NO_R0_FWD: assert (exSrc1 != ZERO_REG || aluASel == 2'b00) else $error("register 0 forwarded"); // R3
    AST_IMM_OPERAND: assert (!exUseImm || (aluBSel == 2'b11 && aluB == exImm)) else $error("immediate not selected"); // R4
    AST_IMM_ONLY: assert (exUseImm || aluBSel != 2'b11 || exSrc2 == ZERO_REG) else $error("code 11 on B without immediate"); // R4
    AST_LINK_ADDR: assert (!exIsLink || (aluASel == 2'b00 && aluA == exPcPlus4)) else $error("link address lost"); // R5
    AST_STORE_NO_LIVE: assert (storeSel != 2'b11) else $error("store data used live path"); // R6
    AST_LIVE_ZERO: assert (!liveZ || (zeroSel == 2'b11 && zeroOperand == liveAlu)) else $error("live value not used"); // R7
    AST_LOAD_HELD: assert (!(m0A && out0IsLoad) || aluASel == 2'b00) else $error("unfinished load forwarded"); // R8
  end
endmodule

bind operand_bypass_unit operand_bypass_chk #(
  .DATA_W(DATA_W),
  .REG_AW(REG_AW)
) chk_i (
  .exSrc1     (exSrc1),
  .exSrc2     (exSrc2),
  .exUseImm   (exUseImm),
  .exIsLink   (exIsLink),
  .exImm      (exImm),
  .exPcPlus4  (exPcPlus4),
  .idZeroSrc  (idZeroSrc),
  .liveDest   (liveDest),
  .liveWrites (liveWrites),
  .liveIsLoad (liveIsLoad),
  .liveAlu    (liveAlu),
  .out0Dest   (out0Dest),
  .out0Writes (out0Writes),
  .out0IsLoad (out0IsLoad),
  .out1Dest   (out1Dest),
  .out1Writes (out1Writes),
  .out1Data   (out1Data),
  .aluASel    (aluASel),
  .aluA       (aluA),
  .aluBSel    (aluBSel),
  .aluB       (aluB),
  .storeSel   (storeSel),
  .zeroSel    (zeroSel),
  .zeroOperand(zeroOperand)
);

// File: tb/operand_bypass_unit_tb_top.sv
module operand_bypass_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int REG_AW = 5;
  localparam int WATCHDOG = 2000;

  localparam logic [DATA_W-1:0] V_RF1  = 32'h1111_0001;
  localparam logic [DATA_W-1:0] V_RF2  = 32'h2222_0002;
  localparam logic [DATA_W-1:0] V_IMM  = 32'h3333_0003;
  localparam logic [DATA_W-1:0] V_PC4  = 32'h4444_0004;
  localparam logic [DATA_W-1:0] V_OUT0 = 32'h5555_0005;
  localparam logic [DATA_W-1:0] V_OUT1 = 32'h6666_0006;
  localparam logic [DATA_W-1:0] V_LIVE = 32'h7777_0007;
  localparam logic [DATA_W-1:0] V_ZRF  = 32'h8888_0008;

  typedef struct packed {
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic [4:0] zs;
    logic       imm;
    logic       link;
    logic [4:0] d0;
    logic       w0;
    logic       l0;
    logic [4:0] d1;
    logic       w1;
    logic [4:0] dl;
    logic       wl;
    logic       ll;
    logic [1:0] eA;
    logic [1:0] eB;
    logic [1:0] eS;
    logic [1:0] eZ;
  } vec_t;

  localparam int N_VEC = 12;
  //                      rs1    rs2    zs   imm  lnk  d0    w0 l0  d1    w1  dl    wl ll  eA    eB    eS    eZ
  localparam vec_t VECS [N_VEC] = '{
    '{5'd1,  5'd2,  5'd3,  0, 0, 5'd9,  1, 0, 5'd10, 1, 5'd11, 1, 0, 2'd0, 2'd0, 2'd0, 2'd0}, // R1 no match
    '{5'd5,  5'd6,  5'd7,  0, 0, 5'd5,  1, 0, 5'd6,  1, 5'd11, 1, 0, 2'd1, 2'd2, 2'd2, 2'd0}, // R1 out0 / out1
    '{5'd4,  5'd4,  5'd4,  0, 0, 5'd4,  1, 0, 5'd4,  1, 5'd4,  1, 0, 2'd1, 2'd1, 2'd1, 2'd3}, // R2 youngest
    '{5'd0,  5'd0,  5'd0,  0, 0, 5'd0,  1, 0, 5'd0,  1, 5'd0,  1, 0, 2'd0, 2'd0, 2'd0, 2'd0}, // R3 reg zero
    '{5'd3,  5'd3,  5'd3,  0, 0, 5'd3,  0, 0, 5'd3,  0, 5'd3,  0, 0, 2'd0, 2'd0, 2'd0, 2'd0}, // R3 no writer
    '{5'd2,  5'd2,  5'd8,  1, 0, 5'd2,  1, 0, 5'd12, 1, 5'd13, 1, 0, 2'd1, 2'd3, 2'd1, 2'd0}, // R4 R6 imm+store
    '{5'd6,  5'd6,  5'd6,  0, 1, 5'd1,  1, 0, 5'd6,  1, 5'd0,  1, 0, 2'd0, 2'd2, 2'd2, 2'd2}, // R5 link
    '{5'd7,  5'd7,  5'd7,  0, 0, 5'd7,  1, 1, 5'd7,  1, 5'd12, 1, 0, 2'd0, 2'd0, 2'd0, 2'd0}, // R8 load out0
    '{5'd9,  5'd1,  5'd9,  0, 0, 5'd9,  1, 0, 5'd9,  1, 5'd9,  1, 1, 2'd1, 2'd0, 2'd0, 2'd0}, // R8 load live
    '{5'd2,  5'd13, 5'd13, 0, 0, 5'd13, 1, 0, 5'd13, 1, 5'd2,  1, 0, 2'd0, 2'd1, 2'd1, 2'd1}, // R7 R2 zero order
    '{5'd4,  5'd5,  5'd5,  1, 1, 5'd4,  1, 0, 5'd5,  1, 5'd15, 1, 0, 2'd0, 2'd3, 2'd2, 2'd2}, // R4 R5 both
    '{5'd14, 5'd14, 5'd14, 0, 0, 5'd20, 1, 0, 5'd14, 1, 5'd21, 1, 0, 2'd2, 2'd2, 2'd2, 2'd2}  // R8 load at out1
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  int   cycles = 0;
  int   nChecks = 0;
  int   nFail = 0;
  bit   done = 1'b0;

  logic [REG_AW-1:0] exSrc1, exSrc2, idZeroSrc, liveDest, out0Dest, out1Dest;
  logic exUseImm, exIsLink, liveWrites, liveIsLoad, out0Writes, out0IsLoad, out1Writes;
  logic [DATA_W-1:0] exRf1, exRf2, exImm, exPcPlus4, idZeroRf, liveAlu, out0Data, out1Data;
  logic [1:0] aluASel, aluBSel, storeSel, zeroSel;
  logic [DATA_W-1:0] aluA, aluB, storeData, zeroOperand;

  always #(CLK_PERIOD / 2) clk = ~clk;

  operand_bypass_unit #(.DATA_W(DATA_W), .REG_AW(REG_AW)) dut_i (
    .exSrc1(exSrc1), .exSrc2(exSrc2), .exUseImm(exUseImm), .exIsLink(exIsLink),
    .exRf1(exRf1), .exRf2(exRf2), .exImm(exImm), .exPcPlus4(exPcPlus4),
    .idZeroSrc(idZeroSrc), .idZeroRf(idZeroRf),
    .liveDest(liveDest), .liveWrites(liveWrites), .liveIsLoad(liveIsLoad), .liveAlu(liveAlu),
    .out0Dest(out0Dest), .out0Writes(out0Writes), .out0IsLoad(out0IsLoad), .out0Data(out0Data),
    .out1Dest(out1Dest), .out1Writes(out1Writes), .out1Data(out1Data),
    .aluASel(aluASel), .aluA(aluA), .aluBSel(aluBSel), .aluB(aluB),
    .storeSel(storeSel), .storeData(storeData), .zeroSel(zeroSel), .zeroOperand(zeroOperand)
  );

  function automatic logic [DATA_W-1:0] pick(input logic [1:0] code, input logic [DATA_W-1:0] base,
                                             input logic [DATA_W-1:0] alt);
    case (code)
      2'd1:    return V_OUT0;
      2'd2:    return V_OUT1;
      2'd3:    return alt;
      default: return base;
    endcase
  endfunction

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic applyVec(input vec_t v);
    @(posedge clk);
    exSrc1 = v.rs1; exSrc2 = v.rs2; idZeroSrc = v.zs; exUseImm = v.imm; exIsLink = v.link;
    out0Dest = v.d0; out0Writes = v.w0; out0IsLoad = v.l0;
    out1Dest = v.d1; out1Writes = v.w1;
    liveDest = v.dl; liveWrites = v.wl; liveIsLoad = v.ll;
    @(negedge clk);
  endtask

  task automatic checkVec(input int idx, input vec_t v);
    string s;
    s = $sformatf("vec %0d R1/R2/R4/R5 operand A", idx);
    check(s, {30'd0, aluASel}, {30'd0, v.eA});
    check(s, aluA, pick(v.eA, v.link ? V_PC4 : V_RF1, V_RF1));
    s = $sformatf("vec %0d R4 operand B", idx);
    check(s, {30'd0, aluBSel}, {30'd0, v.eB});
    check(s, aluB, pick(v.eB, V_RF2, V_IMM));
    s = $sformatf("vec %0d R6 store data", idx);
    check(s, {30'd0, storeSel}, {30'd0, v.eS});
    check(s, storeData, pick(v.eS, V_RF2, V_RF2));
    s = $sformatf("vec %0d R7 zero operand", idx);
    check(s, {30'd0, zeroSel}, {30'd0, v.eZ});
    check(s, zeroOperand, pick(v.eZ, V_ZRF, V_LIVE));
  endtask

  initial begin
    exSrc1 = '0; exSrc2 = '0; idZeroSrc = '0; exUseImm = 1'b0; exIsLink = 1'b0;
    liveDest = '0; liveWrites = 1'b0; liveIsLoad = 1'b0;
    out0Dest = '0; out0Writes = 1'b0; out0IsLoad = 1'b0;
    out1Dest = '0; out1Writes = 1'b0;
    exRf1 = V_RF1; exRf2 = V_RF2; exImm = V_IMM; exPcPlus4 = V_PC4; idZeroRf = V_ZRF;
    liveAlu = V_LIVE; out0Data = V_OUT0; out1Data = V_OUT1;
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Idle state: nothing writes, every path reads its register-file value (R1, R3)
    check("idle R1 operand A code", {30'd0, aluASel}, 32'd0);
    check("idle R3 zero operand", zeroOperand, V_ZRF);

    for (int i = 0; i < N_VEC; i++) begin
      applyVec(VECS[i]);
      checkVec(i, VECS[i]);
    end

    // R4: with the immediate flag set, operand B ignores a change of source 2 producer
    applyVec('{5'd1, 5'd3, 5'd0, 1, 0, 5'd3, 1, 0, 5'd3, 1, 5'd0, 0, 0, 2'd0, 2'd3, 2'd1, 2'd0});
    check("R4 immediate holds B", aluB, V_IMM);
    @(posedge clk);
    exImm = 32'h0BAD_1234;
    @(negedge clk);
    check("R4 immediate value follows input", aluB, 32'h0BAD_1234);
    exImm = V_IMM;

    // R7: live value change propagates to zero operand on a live match
    applyVec('{5'd1, 5'd2, 5'd17, 0, 0, 5'd17, 1, 0, 5'd0, 0, 5'd17, 1, 0, 2'd0, 2'd0, 2'd0, 2'd3});
    @(posedge clk);
    liveAlu = 32'h0000_0000;
    @(negedge clk);
    check("R7 live zero value", zeroOperand, 32'h0000_0000);
    check("R7 live code", {30'd0, zeroSel}, 32'd3);
    liveAlu = V_LIVE;

    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
  end

  initial begin
    wait (done || cycles >= WATCHDOG);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule